// File: doc/BRIEF.md
# Serial Command Register Interface

This block sits behind a byte-oriented serial target port, such as the back end of an I2C target. It turns a stream of bytes into commands and keeps a small register file. A start strobe begins each transaction. In a write transaction the first byte picks a command and every later byte is a parameter of that command, numbered from zero. In a read transaction each byte the host takes returns data for the command latched last, indexed by how many bytes were read since the start.

The register file holds a configuration byte, an active-time byte, a debounce byte, a keypad-size byte, a clock-setup byte and three 16-bit GPIO control words (pull, direction, output state). Each written value is checked against a rule for its command. Any error sets a bit in a sticky error register and raises an error flag in the status byte. An active-low interrupt output stays asserted while the status byte is non-zero.

Once a command has taken its last parameter, the decoder moves into a terminal state. From there, any further parameter byte in the same transaction is reported as a bad parameter.

Top module: `cmd_regfile`

## Requirements
- R1: A start strobe clears the byte counter. On a write, byte 0 is latched as the command code and byte N (N≥1) is parameter N-1. Each read byte increments the read index, which starts at 0.
- R2: After a command takes its final parameter, the latched command becomes 0xFF. Any write byte while 0xFF is latched sets the bad-parameter error (error bit 0).
- R3: After reset: config 0x80, status 0x10 (bit 4 = not initialised), active time 125, debounce 3, keypad size 0x33, clock 0x08, GPIO words 0 and error register 0.
- R4: Command 0x83 restores the R3 values of config, status, active time, debounce, keypad size and clock only when its parameter is 0xAA. Any other parameter sets error bit 0. The error register and the GPIO words are not restored.
- R5: GPIO pull (0x84), direction (0x85) and state (0x86) take parameter 0 as the whole word, with bits 15:8 cleared. Parameter 1 is OR'd into bits 15:8 and completes the command. Reads 0x87 (direction) and 0x88 (state) return byte k as bits 8k+7..8k, and 0 for k≥2.
- R6: Debounce (0x8F) stores its value and flags error bit 0 if the value is 0. Keypad size (0x90) stores its value and flags error bit 0 if bits 3:0 are outside 3..12 or bits 7:4 are outside 3..8. Key size reads back through 0x91. Active time (0x8B) stores its value with no check.
- R7: Clock (0x93) stores its value and flags error bit 0 when bits 1:0 are 01 or 10. Read 0x94 returns the stored bits 7:2 with bits 1:0 forced to 10.
- R8: Read 0x80 returns 0x00, then 0x04, then 0x00 for later bytes. Read 0x92 returns the low nibble of config with the upper nibble zero. Read 0x8E returns 0.
- R9: A command code that is not defined for the direction used sets error bit 1, on every such write parameter byte or read byte. Such a read returns 0x00.
- R10: Any error ORs its code into the error register and sets status bit 3. The error register only accumulates and reads back through 0x8C.
- R11: Read 0x82 returns the status byte (byte 0; later bytes 0). The read clears the status byte unless bit 4 is set. Write 0x81 stores config and clears the status byte. irqN is low exactly while the status byte is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Start of a transaction in either direction |
| wrValid | input | 1 | A written byte is present on wrData |
| wrData | input | 8 | Written byte |
| rdReq | input | 1 | Host takes a read byte this cycle |
| rdData | output | 8 | Read byte for the current command and index, valid combinationally |
| irqN | output | 1 | Low while any status bit is set |
| cfgOut | output | 8 | Configuration byte |
| activeTime | output | 8 | Active-time setting |
| debounceTime | output | 8 | Debounce setting |
| gpioPull | output | 16 | GPIO pull selection word |
| gpioDir | output | 16 | GPIO direction word |
| gpioState | output | 16 | GPIO output state word |

## Verification
The assertions assume that startValid, wrValid and rdReq are never high in the same cycle. They also assume that reads are only requested after a write transaction has latched a command. The bench drives exactly one strobe per cycle at the falling edge and holds each one for a single cycle, so both assumptions hold. The range sweeps check status bit 3 after each value. They read the status byte once initialisation has been cleared, so every trial starts from a clean flag.

// File: rtl/cmd_regfile_pkg.sv
package cmd_regfile_pkg;

  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;
  localparam int WORD_BYTES = WORD_W / BYTE_W;

  localparam logic [7:0] OP_ID      = 8'h80;
  localparam logic [7:0] OP_WCFG    = 8'h81;
  localparam logic [7:0] OP_STAT    = 8'h82;
  localparam logic [7:0] OP_SRST    = 8'h83;
  localparam logic [7:0] OP_WPULL   = 8'h84;
  localparam logic [7:0] OP_WDIR    = 8'h85;
  localparam logic [7:0] OP_WSTATE  = 8'h86;
  localparam logic [7:0] OP_RDIR    = 8'h87;
  localparam logic [7:0] OP_RSTATE  = 8'h88;
  localparam logic [7:0] OP_ACT     = 8'h8B;
  localparam logic [7:0] OP_RERR    = 8'h8C;
  localparam logic [7:0] OP_ROT     = 8'h8E;
  localparam logic [7:0] OP_DBNC    = 8'h8F;
  localparam logic [7:0] OP_WKEY    = 8'h90;
  localparam logic [7:0] OP_RKEY    = 8'h91;
  localparam logic [7:0] OP_RCFG    = 8'h92;
  localparam logic [7:0] OP_WCLK    = 8'h93;
  localparam logic [7:0] OP_RCLK    = 8'h94;
  localparam logic [7:0] OP_DONE    = 8'hFF;

  localparam int ERR_BADPAR_BIT = 0;
  localparam int ERR_UNKCMD_BIT = 1;
  localparam int ST_ERR_BIT     = 3;
  localparam int ST_NOINIT_BIT  = 4;

  typedef struct packed {
    logic              wrCfg;
    logic              softRst;
    logic              pullLo;
    logic              pullHi;
    logic              dirLo;
    logic              dirHi;
    logic              stateLo;
    logic              stateHi;
    logic              wrAct;
    logic              wrDbnc;
    logic              wrKey;
    logic              wrClk;
    logic              rdStat;
    logic              errBadPar;
    logic              errUnkCmd;
    logic [BYTE_W-1:0] data;
  } strobes_t;

  function automatic logic isReadOp(input logic [7:0] op);
    case (op)
      OP_ID, OP_STAT, OP_RDIR, OP_RSTATE, OP_RERR,
      OP_ROT, OP_RKEY, OP_RCFG, OP_RCLK: isReadOp = 1'b1;
      default:                           isReadOp = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/cmd_regfile_ctrl.sv
module cmd_regfile_ctrl
  import cmd_regfile_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startValid,
  input  logic             wrValid,
  input  logic [7:0]       wrData,
  input  logic             rdReq,
  output strobes_t         strb,
  output logic [7:0]       curOp,
  output logic [CNT_W-1:0] curIdx
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] byteCnt;
  logic [7:0]       opReg;
  logic             paramByte;
  logic             readByte;
  logic             finished;

  assign paramByte = !startValid && wrValid && (byteCnt != '0);
  assign readByte  = !startValid && !wrValid && rdReq;
  assign curOp     = opReg;
  assign curIdx    = byteCnt;

  always_comb begin
    strb      = '0;
    strb.data = wrData;
    finished  = 1'b0;
    if (paramByte) begin
      case (opReg)
        OP_WCFG:   begin strb.wrCfg   = 1'b1; finished = 1'b1; end
        OP_SRST:   begin strb.softRst = 1'b1; finished = 1'b1; end
        OP_WPULL: begin
          if (byteCnt == CNT_ONE) strb.pullLo = 1'b1;
          else begin strb.pullHi = 1'b1; finished = 1'b1; end
        end
        OP_WDIR: begin
          if (byteCnt == CNT_ONE) strb.dirLo = 1'b1;
          else begin strb.dirHi = 1'b1; finished = 1'b1; end
        end
        OP_WSTATE: begin
          if (byteCnt == CNT_ONE) strb.stateLo = 1'b1;
          else begin strb.stateHi = 1'b1; finished = 1'b1; end
        end
        OP_ACT:    begin strb.wrAct  = 1'b1; finished = 1'b1; end
        OP_DBNC:   begin strb.wrDbnc = 1'b1; finished = 1'b1; end
        OP_WKEY:   begin strb.wrKey  = 1'b1; finished = 1'b1; end
        OP_WCLK:   begin strb.wrClk  = 1'b1; finished = 1'b1; end
        OP_DONE:   strb.errBadPar = 1'b1;
        default:   strb.errUnkCmd = 1'b1;
      endcase
    end else if (readByte) begin
      strb.rdStat    = (opReg == OP_STAT);
      strb.errUnkCmd = !isReadOp(opReg);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteCnt <= '0;
      opReg   <= OP_DONE;
    end else begin
      if (startValid) begin
        byteCnt <= '0;
      end else if ((wrValid || rdReq) && byteCnt != CNT_MAX) begin
        byteCnt <= byteCnt + CNT_ONE;
      end
      if (!startValid && wrValid && byteCnt == '0) begin
        opReg <= wrData;
      end else if (finished) begin
        opReg <= OP_DONE;
      end
    end
  end

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    startValid |=> (curIdx == '0)); // R1

  AST_OPCODE_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    (!startValid && wrValid && curIdx == '0) |=> (curOp == $past(wrData))); // R1

  AST_KEY_TERMINAL: assert property (@(posedge clk) disable iff (!rstN)
    (!startValid && wrValid && curIdx != '0 && curOp == OP_WKEY) |=> (curOp == OP_DONE)); // R2

  AST_ONE_WRITE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrCfg, strb.softRst, strb.pullLo, strb.pullHi, strb.dirLo, strb.dirHi,
              strb.stateLo, strb.stateHi, strb.wrAct, strb.wrDbnc, strb.wrKey, strb.wrClk,
              strb.errBadPar, strb.errUnkCmd})); // R2

endmodule

// File: rtl/cmd_regfile_regs.sv
module cmd_regfile_regs
  import cmd_regfile_pkg::*;
#(
  parameter int          CNT_W      = 8,
  parameter logic [15:0] ID_VALUE   = 16'h0400,
  parameter logic [7:0]  RST_CFG    = 8'h80,
  parameter logic [7:0]  RST_ACT    = 8'd125,
  parameter logic [7:0]  RST_DBNC   = 8'd3,
  parameter logic [7:0]  RST_KEY    = 8'h33,
  parameter logic [7:0]  RST_CLK    = 8'h08,
  parameter logic [7:0]  UNLOCK_VAL = 8'hAA,
  parameter int          KEY_LO_MIN = 3,
  parameter int          KEY_LO_MAX = 12,
  parameter int          KEY_HI_MIN = 3,
  parameter int          KEY_HI_MAX = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic [7:0]        rdOp,
  input  logic [CNT_W-1:0]  rdIdx,
  output logic [7:0]        rdData,
  output logic              irqN,
  output logic [7:0]        cfgOut,
  output logic [7:0]        activeTime,
  output logic [7:0]        debounceTime,
  output logic [WORD_W-1:0] gpioPull,
  output logic [WORD_W-1:0] gpioDir,
  output logic [WORD_W-1:0] gpioState
);

  localparam logic [7:0] ST_NOINIT = 8'(1 << ST_NOINIT_BIT);
  localparam int         HALF_W    = BYTE_W / 2;

  logic [7:0] cfgReg, actReg, dbncReg, keyReg, clkReg, statusReg, errReg;
  logic [7:0] statusNext;
  logic [WORD_W-1:0] pullReg, dirReg, stateReg;

  logic [HALF_W-1:0] keyLo, keyHi;
  logic keyBad, clkBad, dbncBad, unlockBad, softRstOk, badPar, anyErr;
  logic [7:0] errCode;

  assign keyLo   = strb.data[HALF_W-1:0];
  assign keyHi   = strb.data[BYTE_W-1:HALF_W];
  assign keyBad  = (int'(keyLo) < KEY_LO_MIN) || (int'(keyLo) > KEY_LO_MAX) ||
                   (int'(keyHi) < KEY_HI_MIN) || (int'(keyHi) > KEY_HI_MAX);
  assign clkBad    = strb.data[1] ^ strb.data[0];
  assign dbncBad   = (strb.data == '0);
  assign unlockBad = (strb.data != UNLOCK_VAL);
  assign softRstOk = strb.softRst && !unlockBad;

  assign badPar = strb.errBadPar || (strb.wrKey && keyBad) || (strb.wrClk && clkBad) ||
                  (strb.wrDbnc && dbncBad) || (strb.softRst && unlockBad);
  assign anyErr = badPar || strb.errUnkCmd;

  always_comb begin
    errCode = '0;
    errCode[ERR_BADPAR_BIT] = badPar;
    errCode[ERR_UNKCMD_BIT] = strb.errUnkCmd;
  end

  always_comb begin
    statusNext = statusReg;
    if (softRstOk) begin
      statusNext = ST_NOINIT;
    end else if (strb.wrCfg) begin
      statusNext = '0;
    end else if (strb.rdStat && !statusReg[ST_NOINIT_BIT]) begin
      statusNext = '0;
    end
    if (anyErr) begin
      statusNext[ST_ERR_BIT] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusReg <= ST_NOINIT;
      errReg    <= '0;
    end else begin
      statusReg <= statusNext;
      errReg    <= errReg | errCode;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgReg  <= RST_CFG;
      actReg  <= RST_ACT;
      dbncReg <= RST_DBNC;
      keyReg  <= RST_KEY;
      clkReg  <= RST_CLK;
    end else if (softRstOk) begin
      cfgReg  <= RST_CFG;
      actReg  <= RST_ACT;
      dbncReg <= RST_DBNC;
      keyReg  <= RST_KEY;
      clkReg  <= RST_CLK;
    end else begin
      if (strb.wrCfg)  cfgReg  <= strb.data;
      if (strb.wrAct)  actReg  <= strb.data;
      if (strb.wrDbnc) dbncReg <= strb.data;
      if (strb.wrKey)  keyReg  <= strb.data;
      if (strb.wrClk)  clkReg  <= strb.data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pullReg  <= '0;
      dirReg   <= '0;
      stateReg <= '0;
    end else begin
      if (strb.pullLo)  pullReg  <= WORD_W'(strb.data);
      if (strb.pullHi)  pullReg[WORD_W-1 -: BYTE_W]  <= pullReg[WORD_W-1 -: BYTE_W] | strb.data;
      if (strb.dirLo)   dirReg   <= WORD_W'(strb.data);
      if (strb.dirHi)   dirReg[WORD_W-1 -: BYTE_W]   <= dirReg[WORD_W-1 -: BYTE_W] | strb.data;
      if (strb.stateLo) stateReg <= WORD_W'(strb.data);
      if (strb.stateHi) stateReg[WORD_W-1 -: BYTE_W] <= stateReg[WORD_W-1 -: BYTE_W] | strb.data;
    end
  end

  function automatic logic [7:0] pickByte(input logic [WORD_W-1:0] w, input logic [CNT_W-1:0] k);
    pickByte = '0;
    for (int b = 0; b < WORD_BYTES; b++) begin
      if (int'(k) == b) pickByte = w[b*BYTE_W +: BYTE_W];
    end
  endfunction

  always_comb begin
    case (rdOp)
      OP_ID:     rdData = pickByte(ID_VALUE, rdIdx);
      OP_STAT:   rdData = pickByte(WORD_W'(statusReg), rdIdx);
      OP_RDIR:   rdData = pickByte(dirReg, rdIdx);
      OP_RSTATE: rdData = pickByte(stateReg, rdIdx);
      OP_RERR:   rdData = errReg;
      OP_RKEY:   rdData = keyReg;
      OP_RCFG:   rdData = {4'h0, cfgReg[3:0]};
      OP_RCLK:   rdData = {clkReg[7:2], 2'b10};
      default:   rdData = '0;
    endcase
  end

  assign irqN         = (statusReg == '0);
  assign cfgOut       = cfgReg;
  assign activeTime   = actReg;
  assign debounceTime = dbncReg;
  assign gpioPull     = pullReg;
  assign gpioDir      = dirReg;
  assign gpioState    = stateReg;

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    ((errReg & $past(errReg)) == $past(errReg))); // R10

  AST_ERR_FLAGS_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.errBadPar || strb.errUnkCmd) |=> statusReg[ST_ERR_BIT]); // R10

  AST_CLK_READ_TAG: assert property (@(posedge clk) disable iff (!rstN)
    (rdOp == OP_RCLK) |-> (rdData[1:0] == 2'b10)); // R7

  AST_NOINIT_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdStat && statusReg[ST_NOINIT_BIT]) |=> statusReg[ST_NOINIT_BIT]); // R11

endmodule

// File: rtl/cmd_regfile.sv
module cmd_regfile
  import cmd_regfile_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startValid,
  input  logic        wrValid,
  input  logic [7:0]  wrData,
  input  logic        rdReq,
  output logic [7:0]  rdData,
  output logic        irqN,
  output logic [7:0]  cfgOut,
  output logic [7:0]  activeTime,
  output logic [7:0]  debounceTime,
  output logic [15:0] gpioPull,
  output logic [15:0] gpioDir,
  output logic [15:0] gpioState
);

  strobes_t         strb;
  logic [7:0]       curOp;
  logic [CNT_W-1:0] curIdx;

  cmd_regfile_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startValid (startValid),
    .wrValid    (wrValid),
    .wrData     (wrData),
    .rdReq      (rdReq),
    .strb       (strb),
    .curOp      (curOp),
    .curIdx     (curIdx)
  );

  cmd_regfile_regs #(.CNT_W(CNT_W)) u_regs (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .rdOp         (curOp),
    .rdIdx        (curIdx),
    .rdData       (rdData),
    .irqN         (irqN),
    .cfgOut       (cfgOut),
    .activeTime   (activeTime),
    .debounceTime (debounceTime),
    .gpioPull     (gpioPull),
    .gpioDir      (gpioDir),
    .gpioState    (gpioState)
  );

endmodule

// File: tb/cmd_regfile_tb.sv
module cmd_regfile_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startValid = 1'b0;
  logic        wrValid = 1'b0;
  logic [7:0]  wrData = '0;
  logic        rdReq = 1'b0;
  logic [7:0]  rdData;
  logic        irqN;
  logic [7:0]  cfgOut, activeTime, debounceTime;
  logic [15:0] gpioPull, gpioDir, gpioState;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  cmd_regfile u_dut (
    .clk(clk), .rstN(rstN), .startValid(startValid), .wrValid(wrValid),
    .wrData(wrData), .rdReq(rdReq), .rdData(rdData), .irqN(irqN),
    .cfgOut(cfgOut), .activeTime(activeTime), .debounceTime(debounceTime),
    .gpioPull(gpioPull), .gpioDir(gpioDir), .gpioState(gpioState)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic hwReset();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); @(negedge clk); rstN = 1'b1;
  endtask

  task automatic st();
    @(negedge clk); startValid = 1'b1;
    @(posedge clk); #1 startValid = 1'b0;
  endtask

  task automatic wr(input logic [7:0] b);
    @(negedge clk); wrValid = 1'b1; wrData = b;
    @(posedge clk); #1 wrValid = 1'b0;
  endtask

  task automatic rd(output logic [7:0] v);
    @(negedge clk); rdReq = 1'b1;
    #1 v = rdData;
    @(posedge clk); #1 rdReq = 1'b0;
  endtask

  task automatic cmd1(input logic [7:0] op, input logic [7:0] p);
    st(); wr(op); wr(p);
  endtask

  task automatic rdOp(input logic [7:0] op, output logic [7:0] v);
    st(); wr(op); st(); rd(v);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, a, b, c;
    hwReset();

    // R3 reset values
    #1;
    chk("R3 irqN", 16'(irqN), 16'h0);
    chk("R3 cfg", 16'(cfgOut), 16'h80);
    chk("R3 act", 16'(activeTime), 16'd125);
    chk("R3 dbnc", 16'(debounceTime), 16'd3);
    chk("R3 gpio", gpioPull | gpioDir | gpioState, 16'h0);
    rdOp(8'h91, v); chk("R3 keysize", 16'(v), 16'h33);
    rdOp(8'h94, v); chk("R3 R7 clock", 16'(v), 16'h0A);
    rdOp(8'h92, v); chk("R3 R8 cfg nibble", 16'(v), 16'h00);
    rdOp(8'h8C, v); chk("R3 err", 16'(v), 16'h00);
    rdOp(8'h82, v); chk("R3 status", 16'(v), 16'h10);
    rdOp(8'h82, v); chk("R11 noinit kept", 16'(v), 16'h10);

    // R8 identity bytes and R1 read index restart
    st(); wr(8'h80); st(); rd(a); rd(b); rd(c);
    chk("R8 id0", 16'(a), 16'h00);
    chk("R8 id1", 16'(b), 16'h04);
    chk("R8 id2", 16'(c), 16'h00);
    st(); rd(a); rd(b);
    chk("R1 idx restart 0", 16'(a), 16'h00);
    chk("R1 idx restart 1", 16'(b), 16'h04);
    rdOp(8'h8E, v); chk("R8 rotator", 16'(v), 16'h00);

    // R11 config write clears status
    cmd1(8'h81, 8'hA5);
    #1 chk("R11 irq release", 16'(irqN), 16'h1);
    chk("R11 cfg stored", 16'(cfgOut), 16'hA5);
    rdOp(8'h92, v); chk("R8 cfg low nibble", 16'(v), 16'h05);
    rdOp(8'h82, v); chk("R11 status clear", 16'(v), 16'h00);

    // R4 soft reset
    cmd1(8'h83, 8'h55);
    #1 chk("R11 irq on err", 16'(irqN), 16'h0);
    rdOp(8'h82, v); chk("R4 bad unlock status", 16'(v), 16'h08);
    rdOp(8'h82, v); chk("R11 read cleared", 16'(v), 16'h00);
    rdOp(8'h8C, v); chk("R4 bad unlock err", 16'(v), 16'h01);
    cmd1(8'h90, 8'h44);
    cmd1(8'h8B, 8'h10);
    st(); wr(8'h85); wr(8'h3C); wr(8'h01);
    cmd1(8'h83, 8'hAA);
    rdOp(8'h91, v); chk("R4 key restored", 16'(v), 16'h33);
    chk("R4 act restored", 16'(activeTime), 16'd125);
    chk("R4 cfg restored", 16'(cfgOut), 16'h80);
    chk("R4 gpio kept", gpioDir, 16'h013C);
    rdOp(8'h82, v); chk("R4 status noinit", 16'(v), 16'h10);
    rdOp(8'h8C, v); chk("R4 R10 err sticky", 16'(v), 16'h01);

    // R9 unknown codes, R10 accumulation
    cmd1(8'h8A, 8'h12);
    rdOp(8'h81, v); chk("R9 unknown read data", 16'(v), 16'h00);
    rdOp(8'h8C, v); chk("R9 R10 err accum", 16'(v), 16'h03);
    rdOp(8'h82, v); chk("R10 status bits", 16'(v), 16'h18);

    // R2 terminal state
    hwReset();
    cmd1(8'h81, 8'h00);
    st(); wr(8'h8B); wr(8'h07); wr(8'h09);
    chk("R2 act first param", 16'(activeTime), 16'h07);
    rdOp(8'h82, v); chk("R2 extra byte status", 16'(v), 16'h08);
    rdOp(8'h8C, v); chk("R2 extra byte err", 16'(v), 16'h01);

    // R1 start mid-command re-latches opcode
    st(); wr(8'h85); wr(8'h11); st(); wr(8'h8B); wr(8'h22);
    chk("R1 relatch act", 16'(activeTime), 16'h22);
    chk("R1 R5 lo only", gpioDir, 16'h0011);
    rdOp(8'h82, v); chk("R1 no error", 16'(v), 16'h00);

    // R5 GPIO sweep
    for (int i = 0; i < 16; i++) begin
      logic [7:0] lo, hi;
      lo = 8'(i * 17 + 1);
      hi = 8'(i * 29 + 3);
      st(); wr(8'h84); wr(lo); wr(hi);
      chk("R5 pull", gpioPull, {hi, lo});
      st(); wr(8'h85); wr(hi); wr(lo);
      st(); wr(8'h87); st(); rd(a); rd(b); rd(c);
      chk("R5 dir b0", 16'(a), 16'(hi));
      chk("R5 dir b1", 16'(b), 16'(lo));
      chk("R5 dir b2", 16'(c), 16'h00);
      st(); wr(8'h86); wr(lo); wr(hi);
      st(); wr(8'h88); st(); rd(a); rd(b);
      chk("R5 state word", {b, a}, {hi, lo});
      chk("R5 state port", gpioState, {hi, lo});
      st(); wr(8'h86); wr(hi);
      chk("R5 lo replaces", gpioState, 16'(hi));
      rdOp(8'h82, v); chk("R5 no error", 16'(v), 16'h00);
    end

    // R6 key size, debounce; R7 clock; full byte sweeps
    for (int i = 0; i < 256; i++) begin
      logic [7:0] p;
      logic bad;
      p = 8'(i);
      bad = (p[3:0] < 4'd3) || (p[3:0] > 4'd12) || (p[7:4] < 4'd3) || (p[7:4] > 4'd8);
      cmd1(8'h90, p);
      rdOp(8'h82, v); chk("R6 key check", 16'(v[3]), 16'(bad));
      rdOp(8'h91, v); chk("R6 key stored", 16'(v), 16'(p));
      cmd1(8'h8F, p);
      rdOp(8'h82, v); chk("R6 dbnc check", 16'(v[3]), 16'(p == 8'h00));
      chk("R6 dbnc stored", 16'(debounceTime), 16'(p));
      cmd1(8'h93, p);
      rdOp(8'h82, v); chk("R7 clk check", 16'(v[3]), 16'(p[1] ^ p[0]));
      rdOp(8'h94, v); chk("R7 clk read", 16'(v), 16'({p[7:2], 2'b10}));
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule